// File: doc/BRIEF.md
# Three-Mode Asynchronous Serial Port

This block is a full-duplex asynchronous serial port built around a transmit shift path and a receive shift path that run independently of each other. A two-bit mode field selects the frame. In the byte mode a frame has ten bits: a low start bit, eight data bits and a high stop bit. In the two nine-bit modes an extra data bit follows the eighth data bit, which gives eleven bits per frame. The ninth bit can be used as an address/data marker between several nodes on one line. Every bit takes sixteen pulses of an external oversampling tick, so the bit rate is set outside the block.

Software starts a transmission by pulsing a write strobe with the byte. The ninth bit and the mode must already be set. Reception is enabled by a control bit and begins on a falling edge of the line. The start bit is then validated at its middle. A received frame is stored in a holding register together with a status bit. In the nine-bit modes that status bit holds the ninth bit. In the byte mode it holds the sampled stop bit. A transmit-complete flag and a receive-complete flag stay set until software clears them. An address-filter control can discard nine-bit frames whose ninth bit is zero. A frame that arrives while the receive flag is still set is dropped.

Top module: `serial_port_multimode`

## Requirements
- R1: After reset, txd is high, tx_done and rx_done are 0, rx_data is 0x00 and rx_bit9 is 0.
- R2: In mode_sel=01, a tx_wr pulse sends on txd a low start bit, then tx_data bits 0 to 7 in that order, then a high stop bit. Each bit lasts 16 baud_tick pulses.
- R3: In mode_sel=10 or 11, the frame on txd carries tx_bit9 as a ninth data bit between data bit 7 and the stop bit.
- R4: tx_done becomes 1 when the stop bit begins on txd. It stays 1 until ti_clr is pulsed. A tx_wr pulse during a frame is ignored, and the frame in progress continues unchanged.
- R5: With mode_sel=00 the port stays idle: a tx_wr pulse leaves txd high, and a frame on rxd does not set rx_done.
- R6: In mode_sel=01, a received frame loads its eight data bits (first received bit into bit 0) into rx_data and sets rx_done. The sampled stop-bit level goes into rx_bit9.
- R7: In mode_sel=10 or 11, a received frame loads the eight data bits into rx_data and the ninth bit into rx_bit9, and sets rx_done.
- R8: Frames on rxd are received only while rx_en is 1. With rx_en at 0, rx_done stays 0 and rx_data keeps its value.
- R9: A low pulse on rxd that has ended by the middle of the start bit (8 ticks after the falling edge) is rejected. No frame is received, and the next proper frame is received normally.
- R10: In mode_sel=10 or 11 with addr_filter=1, a frame whose ninth bit is 0 is discarded (rx_done stays 0, rx_data unchanged). A frame whose ninth bit is 1 is accepted.
- R11: A frame that completes while rx_done is 1 is dropped, and rx_data and rx_bit9 keep the earlier frame.
- R12: A ri_clr pulse clears rx_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling pulse, 16 per bit time |
| mode_sel | input | 2 | 00 off, 01 byte frame, 10/11 nine-bit frame |
| tx_wr | input | 1 | Write strobe that starts a transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth bit to transmit in nine-bit modes |
| rx_en | input | 1 | Receive enable |
| addr_filter | input | 1 | Discard nine-bit frames whose ninth bit is 0 |
| ti_clr | input | 1 | Clears tx_done |
| ri_clr | input | 1 | Clears rx_done |
| rx_data | output | 8 | Last accepted received byte |
| rx_bit9 | output | 1 | Received ninth bit, or stop bit in byte mode |
| tx_done | output | 1 | Transmit-complete flag |
| rx_done | output | 1 | Receive-complete flag |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
txd falls on the clock edge that takes in tx_wr. The bench times each transmit bit from that fall and samples it 32 clocks (half a bit) into its window, and every later bit 64 clocks after the one before. This keeps each sample well inside the bit despite the unknown tick phase. tx_done is due at the start of the stop bit, so the bench checks it low at the start-bit sample and high at the stop-bit sample. rx_done, rx_data and rx_bit9 are loaded at the middle of the received stop bit. The bench reads them 16 clocks after it has driven the whole stop bit, which is before the next stimulus. Rejected, filtered and dropped frames are checked at that same point.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    SP_OFF    = 2'b00,
    SP_BYTE   = 2'b01,
    SP_NINE_A = 2'b10,
    SP_NINE_B = 2'b11
  } sp_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_STOP
  } sp_phase_e;
endpackage

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          port_on,
  input  logic          nine,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          bit9,
  input  logic          clr,
  output logic          done,
  output logic          line
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_END = CW'(OVS - 1);
  localparam logic [BW-1:0] END8    = BW'(DW - 1);
  localparam logic [BW-1:0] END9    = BW'(DW);

  sp_phase_e     ph;
  logic [CW-1:0] cnt;
  logic [BW-1:0] idx;
  logic [DW:0]   sh;
  logic          nine_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      nine_q <= 1'b0;
      line   <= 1'b1;
      done   <= 1'b0;
    end else begin
      if (clr) done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (wr && port_on) begin
            sh     <= {bit9, wdata};
            nine_q <= nine;
            cnt    <= '0;
            idx    <= '0;
            line   <= 1'b0;
            ph     <= PH_START;
          end
        end
        PH_START: begin
          if (tick) begin
            if (cnt == CNT_END) begin
              cnt  <= '0;
              line <= sh[0];
              sh   <= sh >> 1;
              ph   <= PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (tick) begin
            if (cnt == CNT_END) begin
              cnt <= '0;
              if (idx == (nine_q ? END9 : END8)) begin
                line <= 1'b1;
                done <= 1'b1;
                ph   <= PH_STOP;
              end else begin
                line <= sh[0];
                sh   <= sh >> 1;
                idx  <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (cnt == CNT_END) begin
              cnt <= '0;
              ph  <= PH_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE) |-> line);
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_START) |-> !line);
  p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_STOP) |-> line);
  p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> done);
  p_off_stays_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE && !port_on) |=> (ph == PH_IDLE));
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          port_on,
  input  logic          nine,
  input  logic          en,
  input  logic          filt,
  input  logic          clr,
  input  logic          line,
  output logic [DW-1:0] data,
  output logic          b9,
  output logic          done
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_END = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID = CW'(OVS / 2 - 1);
  localparam logic [BW-1:0] END8    = BW'(DW - 1);
  localparam logic [BW-1:0] END9    = BW'(DW);

  logic          s1, s2, s3;
  sp_phase_e     ph;
  logic [CW-1:0] cnt;
  logic [BW-1:0] idx;
  logic [DW:0]   sh;
  logic          nine_q;
  logic          keep;

  assign keep = !done && en && !(filt && nine_q && !sh[DW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= line;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      nine_q <= 1'b0;
      data   <= '0;
      b9     <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (clr) done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (en && port_on && s3 && !s2) begin
            nine_q <= nine;
            cnt    <= '0;
            ph     <= PH_START;
          end
        end
        PH_START: begin
          if (tick) begin
            if (cnt == CNT_MID) begin
              cnt <= '0;
              idx <= '0;
              ph  <= s2 ? PH_IDLE : PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (tick) begin
            if (cnt == CNT_END) begin
              cnt     <= '0;
              sh[idx] <= s2;
              idx     <= idx + 1'b1;
              if (idx == (nine_q ? END9 : END8)) ph <= PH_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (cnt == CNT_END) begin
              cnt <= '0;
              ph  <= PH_IDLE;
              if (keep) begin
                data <= sh[DW-1:0];
                b9   <= nine_q ? sh[DW] : s2;
                done <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  p_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(en));
  p_filter_accepts_marked_r10: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && $past(filt && nine_q)) |-> b9);
  p_hold_on_overrun_r11: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> ($stable(data) && $stable(b9)));
  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (clr && ph != PH_STOP) |=> !done);
endmodule

// File: rtl/serial_port_multimode.sv
module serial_port_multimode
  import sport_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic [1:0]    mode_sel,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit9,
  input  logic          rx_en,
  input  logic          addr_filter,
  input  logic          ti_clr,
  input  logic          ri_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          tx_done,
  output logic          rx_done,
  input  logic          rxd,
  output logic          txd
);
  sp_mode_e mode;
  logic     port_on;
  logic     nine;

  assign mode    = sp_mode_e'(mode_sel);
  assign port_on = (mode != SP_OFF);
  assign nine    = (mode == SP_NINE_A) || (mode == SP_NINE_B);

  sport_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(baud_tick), .port_on(port_on), .nine(nine),
    .wr(tx_wr), .wdata(tx_data), .bit9(tx_bit9), .clr(ti_clr),
    .done(tx_done), .line(txd)
  );

  sport_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(baud_tick), .port_on(port_on), .nine(nine),
    .en(rx_en), .filt(addr_filter), .clr(ri_clr), .line(rxd),
    .data(rx_data), .b9(rx_bit9), .done(rx_done)
  );
endmodule

// File: tb/tb_serial_port_multimode.sv
module tb_serial_port_multimode;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BITC       = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick;
  logic [1:0] mode_sel = 2'b00;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_bit9 = 1'b0;
  logic       rx_en = 1'b0;
  logic       addr_filter = 1'b0;
  logic       ti_clr = 1'b0;
  logic       ri_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, tx_done, rx_done;
  logic       rxd = 1'b1;
  logic       txd;

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;
  int tdc  = 0;

  serial_port_multimode dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .mode_sel(mode_sel),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit9(tx_bit9), .rx_en(rx_en),
    .addr_filter(addr_filter), .ti_clr(ti_clr), .ri_clr(ri_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .tx_done(tx_done), .rx_done(rx_done),
    .rxd(rxd), .txd(txd)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) tdc <= (tdc == TDIV - 1) ? 0 : tdc + 1;
  assign baud_tick = (tdc == TDIV - 1);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errs++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic frame_bit(int k, logic [7:0] d, logic b9);
    return (k < 8) ? d[k] : b9;
  endfunction

  function automatic logic exp_rb8(logic [1:0] m, logic b9, logic stopv);
    return (m == 2'b01) ? stopv : b9;
  endfunction

  function automatic logic exp_keep(logic [1:0] m, logic en, logic filt,
                                    logic b9, logic ri_before);
    return (m != 2'b00) && en && !ri_before && !(filt && m[1] && !b9);
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // Transmit one frame and sample every bit near its centre.
  task automatic tx_frame(logic [1:0] m, logic [7:0] d, logic b9, bit poke);
    int nb;
    nb = m[1] ? 9 : 8;
    @(negedge clk);
    mode_sel = m; tx_data = d; tx_bit9 = b9; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    wait_clk(31);
    chk("R2 start bit", txd, 1'b0);
    chk("R4 tx_done low before stop", tx_done, 1'b0);
    for (int k = 0; k < nb; k++) begin
      if (poke && k == 0) begin
        @(negedge clk);
        tx_data = ~d; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        wait_clk(BITC - 2);
      end else begin
        wait_clk(BITC);
      end
      chk(k < 8 ? (poke ? "R4 busy write ignored" : "R2 data bit") : "R3 ninth bit",
          txd, frame_bit(k, d, b9));
    end
    wait_clk(BITC);
    chk("R2 stop bit", txd, 1'b1);
    chk("R4 tx_done at stop", tx_done, 1'b1);
    wait_clk(BITC);
    chk("R4 tx_done sticky", tx_done, 1'b1);
    ti_clr = 1'b1;
    @(negedge clk);
    ti_clr = 1'b0;
    @(negedge clk);
    chk("R4 tx_done cleared", tx_done, 1'b0);
  endtask

  // Drive one frame on rxd.
  task automatic rx_drive(logic [1:0] m, logic [7:0] d, logic b9, logic stopv);
    int nb;
    nb = m[1] ? 9 : 8;
    @(negedge clk);
    rxd = 1'b0;
    wait_clk(BITC);
    for (int k = 0; k < nb; k++) begin
      rxd = frame_bit(k, d, b9);
      wait_clk(BITC);
    end
    rxd = stopv;
    wait_clk(BITC);
    rxd = 1'b1;
    wait_clk(16);
  endtask

  // Receive one frame and compare against the expected register state.
  task automatic rx_frame(string req, logic [1:0] m, logic [7:0] d, logic b9,
                          logic stopv, bit clear_after);
    logic       keep;
    logic [7:0] old_d;
    logic       old_b;
    logic       old_ri;
    old_d  = rx_data;
    old_b  = rx_bit9;
    old_ri = rx_done;
    mode_sel = m;
    keep = exp_keep(m, rx_en, addr_filter, b9, old_ri);
    rx_drive(m, d, b9, stopv);
    chk(req, rx_done, keep | old_ri);
    chk(req, rx_data, keep ? d : old_d);
    chk(req, rx_bit9, keep ? exp_rb8(m, b9, stopv) : old_b);
    if (clear_after) begin
      ri_clr = 1'b1;
      @(negedge clk);
      ri_clr = 1'b0;
      @(negedge clk);
      chk("R12 rx_done cleared", rx_done, 1'b0);
    end
  endtask

  initial begin
    logic [1:0] m;
    logic [7:0] d;
    logic       b;
    void'($urandom(32'h5EED));
    wait_clk(5);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 tx_done", tx_done, 1'b0);
    chk("R1 rx_done", rx_done, 1'b0);
    chk("R1 rx_data", rx_data, 8'h00);
    chk("R1 rx_bit9", rx_bit9, 1'b0);

    // R5: off mode ignores writes and incoming frames.
    @(negedge clk);
    mode_sel = 2'b00; tx_data = 8'h00; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      wait_clk(50);
      chk("R5 txd stays high", txd, 1'b1);
    end
    rx_en = 1'b1;
    rx_frame("R5 off mode rx ignored", 2'b00, 8'h3C, 1'b1, 1'b1, 1'b0);

    // Directed transmit frames.
    tx_frame(2'b01, 8'hA5, 1'b0, 1'b0);
    tx_frame(2'b10, 8'h00, 1'b1, 1'b0);
    tx_frame(2'b11, 8'hFF, 1'b0, 1'b0);
    tx_frame(2'b01, 8'h96, 1'b0, 1'b1);

    // Random transmit frames.
    for (int i = 0; i < 6; i++) begin
      m = 2'($urandom_range(3, 1));
      d = 8'($urandom);
      b = 1'($urandom);
      tx_frame(m, d, b, 1'b0);
    end

    // Directed receive frames.
    rx_frame("R6 byte mode rx", 2'b01, 8'h5A, 1'b0, 1'b1, 1'b1);
    rx_frame("R6 byte mode low stop", 2'b01, 8'hC3, 1'b1, 1'b0, 1'b1);
    rx_frame("R7 nine-bit rx", 2'b10, 8'h81, 1'b1, 1'b1, 1'b1);
    rx_frame("R7 nine-bit rx b9=0", 2'b11, 8'h7E, 1'b0, 1'b1, 1'b1);

    // R8: receiver disabled.
    rx_en = 1'b0;
    rx_frame("R8 disabled rx ignored", 2'b01, 8'h11, 1'b0, 1'b1, 1'b0);
    rx_en = 1'b1;

    // R9: short glitch rejected, then a good frame.
    @(negedge clk);
    mode_sel = 2'b01;
    rxd = 1'b0;
    wait_clk(12);
    rxd = 1'b1;
    wait_clk(BITC * 12);
    chk("R9 glitch rejected", rx_done, 1'b0);
    rx_frame("R9 frame after glitch", 2'b01, 8'h24, 1'b0, 1'b1, 1'b1);

    // R10: address filter.
    addr_filter = 1'b1;
    rx_frame("R10 filtered b9=0", 2'b10, 8'h99, 1'b0, 1'b1, 1'b0);
    rx_frame("R10 accepted b9=1", 2'b11, 8'h42, 1'b1, 1'b1, 1'b1);
    addr_filter = 1'b0;

    // R11: overrun keeps the first frame.
    rx_frame("R11 first frame", 2'b10, 8'hE7, 1'b1, 1'b1, 1'b0);
    rx_frame("R11 overrun dropped", 2'b10, 8'h18, 1'b0, 1'b1, 1'b1);

    // Random receive frames.
    for (int i = 0; i < 8; i++) begin
      m = 2'($urandom_range(3, 1));
      d = 8'($urandom);
      b = 1'($urandom);
      addr_filter = 1'($urandom);
      rx_frame(m == 2'b01 ? "R6 random rx" : "R7 random rx", m, d, b, 1'b1, 1'b1);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule